// File: doc/BRIEF.md
# VPD EEPROM access engine

This block carries out vital-product-data transfers between a configuration register pair and an external serial EEPROM with a Microwire-style four-wire interface (16-bit word organisation). Software writes a byte address together with a direction flag. With the flag at 1 the engine stores the 32-bit data register into the EEPROM. With the flag at 0 it fills the data register from the EEPROM. The engine reports completion by inverting the same flag bit, so software polls one bit for both directions.

Each access moves four consecutive bytes as two 16-bit word operations on the serial bus. Before the two word writes of a store, a write-enable command is sent. After each word write the engine drops chip select, raises it again, waits out the status-valid time and polls the ready level on the EEPROM data output. The serial clock is produced from the core clock by a parameterised divider. Configuration writes that arrive while a transfer is running are dropped.

Top module: `vpd_eeprom_engine`

## Requirements
- R1: After reset the flag, address and data registers read 0, and chip select, serial clock and serial data to the EEPROM are all low.
- R2: A command with flag 1 stores data bits 15:0 at EEPROM word (byte address / 2) and bits 31:16 at the next word. It first sends a write-enable frame: start bit 1, opcode 00, two address MSBs 11, rest 0. Each word write frame is start bit 1, opcode 01, word address, then 16 data bits, all MSB first. A data-register write while idle is visible on `vpd_data` on the next cycle.
- R3: One cycle after a command is accepted, `vpd_flag` equals the written flag. It keeps that value until the whole transfer is finished, and then holds the inverse.
- R4: A command with flag 0 sends a read frame per word: start bit 1, opcode 10, word address. It then clocks in 16 data bits MSB first and leaves `vpd_data` = {word(byte address / 2 + 1), word(byte address / 2)}.
- R5: Address bits 1:0 are ignored. The access and `vpd_addr` use the address with those bits cleared.
- R6: Every double word of the array is reachable, including the last one at byte address 2^(EE_ABITS+1) - 4.
- R7: Writes to the address or data register while a transfer runs have no effect on the registers, the EEPROM or the flag.
- R8: Each serial clock high phase lasts exactly SK_HALF core cycles. Serial data only changes while the serial clock is low, and the serial clock is only high while chip select is high.
- R9: After each word write, completion is not reported before the EEPROM data output shows ready (high). A slow EEPROM therefore lengthens the transfer by its full busy time per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr_we | input | 1 | Configuration write strobe for the address/flag register |
| cfg_addr | input | EE_ABITS+1 | Byte address written with the strobe |
| cfg_flag | input | 1 | Direction flag written with the address (1 store, 0 fetch) |
| cfg_data_we | input | 1 | Configuration write strobe for the data register |
| cfg_data | input | 32 | Data written with the strobe |
| vpd_addr | output | EE_ABITS+1 | Current address register (bits 1:0 always 0) |
| vpd_flag | output | 1 | Command/completion flag |
| vpd_data | output | 32 | Current data register |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The main function is driven with stores and fetches at the first double word, an interior one and the last one of the array. Distinct bit patterns in each half show whether the halves land in the right words and in the right order. A fetch of a never-written location separates real EEPROM reads from stale register contents. Unaligned addresses show whether the two low bits are discarded. A fetch with a store attempted on top of it shows whether busy-time writes leak through. A long EEPROM busy time shows whether completion truly waits for the ready level.

// File: rtl/vpd_pkg.sv
package vpd_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CSUP,
        ST_SHIFT,
        ST_CSHOLD,
        ST_GAP,
        ST_STAT,
        ST_POLL
    } vpd_state_e;

    // order matters: a store walks EWEN->WLO->WHI, a fetch walks RLO->RHI
    typedef enum logic [2:0] {
        OP_EWEN,
        OP_WLO,
        OP_WHI,
        OP_RLO,
        OP_RHI
    } vpd_op_e;

    // start bit followed by the two opcode bits
    localparam logic [2:0] HDR_READ  = 3'b110;
    localparam logic [2:0] HDR_WRITE = 3'b101;
    localparam logic [2:0] HDR_MISC  = 3'b100;

endpackage

// File: rtl/vpd_frame_compose.sv
module vpd_frame_compose
    import vpd_pkg::*;
#(
    parameter  int EE_ABITS = 8,
    localparam int FRAME_W  = 3 + EE_ABITS + WORD_W,
    localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
    input  vpd_op_e                 op,
    input  logic [EE_ABITS-1:0]     word_addr,
    input  logic [2*WORD_W-1:0]     wdata,
    output logic [FRAME_W-1:0]      frame,
    output logic [CNT_W-1:0]        nbits
);

    logic [EE_ABITS-1:0] word_addr_odd;
    assign word_addr_odd = word_addr | EE_ABITS'(1);

    always_comb begin
        frame = '0;
        nbits = CNT_W'(FRAME_W);
        unique case (op)
            OP_EWEN: begin
                frame = {HDR_MISC, 2'b11, {(EE_ABITS-2){1'b0}}, {WORD_W{1'b0}}};
                nbits = CNT_W'(3 + EE_ABITS);
            end
            OP_WLO:  frame = {HDR_WRITE, word_addr,     wdata[WORD_W-1:0]};
            OP_WHI:  frame = {HDR_WRITE, word_addr_odd, wdata[2*WORD_W-1:WORD_W]};
            OP_RLO:  frame = {HDR_READ,  word_addr,     {WORD_W{1'b0}}};
            OP_RHI:  frame = {HDR_READ,  word_addr_odd, {WORD_W{1'b0}}};
            default: frame = '0;
        endcase
    end

endmodule

// File: rtl/vpd_sk_shifter.sv
module vpd_sk_shifter
    import vpd_pkg::*;
#(
    parameter  int FRAME_W = 27,
    parameter  int SK_HALF = 4,
    localparam int CNT_W   = $clog2(FRAME_W + 1),
    localparam int TMR_W   = (SK_HALF > 1) ? $clog2(SK_HALF) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [FRAME_W-1:0]   frame,
    input  logic [CNT_W-1:0]     nbits,
    input  logic                 so_in,
    output logic                 sk,
    output logic                 di,
    output logic                 done,
    output logic [WORD_W-1:0]    rx_word
);

    localparam logic [TMR_W-1:0] TMR_LD = TMR_W'(SK_HALF - 1);

    typedef struct packed {
        logic                active;
        logic                sk;
        logic                done;
        logic [TMR_W-1:0]    tmr;
        logic [CNT_W-1:0]    cnt;
        logic [FRAME_W-1:0]  sh;
        logic [WORD_W-1:0]   rx;
    } shf_t;

    shf_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (!r_q.active) begin
            if (start) begin
                r_d.active = 1'b1;
                r_d.sk     = 1'b0;
                r_d.tmr    = TMR_LD;
                r_d.cnt    = nbits;
                r_d.sh     = frame;
            end
        end else if (r_q.tmr != '0) begin
            r_d.tmr = r_q.tmr - 1'b1;
        end else if (!r_q.sk) begin
            r_d.sk  = 1'b1;
            r_d.tmr = TMR_LD;
        end else begin
            // falling edge: capture EEPROM output, advance to next bit
            r_d.sk  = 1'b0;
            r_d.tmr = TMR_LD;
            r_d.rx  = {r_q.rx[WORD_W-2:0], so_in};
            r_d.sh  = r_q.sh << 1;
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.active = 1'b0;
                r_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sk      = r_q.sk;
    assign di      = r_q.active & r_q.sh[FRAME_W-1];
    assign done    = r_q.done;
    assign rx_word = r_q.rx;

    // R8: data to the EEPROM holds while the serial clock is high
    assert_di_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sk && $past(sk)) |-> $stable(di));

    // R8: the sequencer never restarts a frame that is still shifting
    assert_start_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !r_q.active);

endmodule

// File: rtl/vpd_eeprom_engine.sv
module vpd_eeprom_engine
    import vpd_pkg::*;
#(
    parameter  int EE_ABITS = 8,
    parameter  int SK_HALF  = 200,
    parameter  int TSV_CYC  = 100,
    localparam int ADDR_W   = EE_ABITS + 1,
    localparam int DATA_W   = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_addr_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_flag,
    input  logic              cfg_data_we,
    input  logic [DATA_W-1:0] cfg_data,
    output logic [ADDR_W-1:0] vpd_addr,
    output logic              vpd_flag,
    output logic [DATA_W-1:0] vpd_data,
    output logic              ee_cs,
    output logic              ee_sk,
    output logic              ee_di,
    input  logic              ee_do
);

    localparam int FRAME_W = 3 + EE_ABITS + WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int TMR_MAX = (SK_HALF > TSV_CYC) ? SK_HALF : TSV_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] HALF_LD = TMR_W'(SK_HALF - 1);
    localparam logic [TMR_W-1:0] TSV_LD  = TMR_W'(TSV_CYC - 1);

    typedef struct packed {
        vpd_state_e           state;
        vpd_op_e              op;
        logic [TMR_W-1:0]     tmr;
        logic [ADDR_W-1:0]    addr;
        logic                 flag;
        logic [DATA_W-1:0]    data;
        logic                 cs;
        logic                 poll_pend;
        logic                 start;
        logic [1:0]           do_sync;
    } eng_t;

    eng_t r_q, r_d;

    logic [FRAME_W-1:0] frame;
    logic [CNT_W-1:0]   nbits;
    logic               sh_done;
    logic [WORD_W-1:0]  rx_word;
    logic               do_s;
    logic               addr_lsb_unused;

    assign addr_lsb_unused = ^cfg_addr[1:0];
    assign do_s            = r_q.do_sync[1];

    vpd_frame_compose #(.EE_ABITS(EE_ABITS)) u_frame (
        .op        (r_q.op),
        .word_addr (r_q.addr[ADDR_W-1:1]),
        .wdata     (r_q.data),
        .frame     (frame),
        .nbits     (nbits)
    );

    vpd_sk_shifter #(.FRAME_W(FRAME_W), .SK_HALF(SK_HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (r_q.start),
        .frame   (frame),
        .nbits   (nbits),
        .so_in   (do_s),
        .sk      (ee_sk),
        .di      (ee_di),
        .done    (sh_done),
        .rx_word (rx_word)
    );

    always_comb begin
        r_d         = r_q;
        r_d.start   = 1'b0;
        r_d.do_sync = {r_q.do_sync[0], ee_do};
        unique case (r_q.state)
            ST_IDLE: begin
                if (cfg_data_we) r_d.data = cfg_data;
                if (cfg_addr_we) begin
                    r_d.addr  = {cfg_addr[ADDR_W-1:2], 2'b00};
                    r_d.flag  = cfg_flag;
                    r_d.op    = cfg_flag ? OP_EWEN : OP_RLO;
                    r_d.cs    = 1'b1;
                    r_d.tmr   = HALF_LD;
                    r_d.state = ST_CSUP;
                end
            end
            ST_CSUP: begin
                if (r_q.tmr == '0) begin
                    r_d.start = 1'b1;
                    r_d.state = ST_SHIFT;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (r_q.op == OP_RLO) r_d.data[WORD_W-1:0]      = rx_word;
                    if (r_q.op == OP_RHI) r_d.data[DATA_W-1:WORD_W] = rx_word;
                    if (r_q.op == OP_WLO || r_q.op == OP_WHI) r_d.poll_pend = 1'b1;
                    r_d.tmr   = HALF_LD;
                    r_d.state = ST_CSHOLD;
                end
            end
            ST_CSHOLD: begin
                if (r_q.tmr == '0) begin
                    r_d.cs    = 1'b0;
                    r_d.tmr   = HALF_LD;
                    r_d.state = ST_GAP;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_GAP: begin
                if (r_q.tmr != '0) begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end else if (r_q.poll_pend) begin
                    r_d.poll_pend = 1'b0;
                    r_d.cs        = 1'b1;
                    r_d.tmr       = TSV_LD;
                    r_d.state     = ST_STAT;
                end else if (r_q.op == OP_WHI || r_q.op == OP_RHI) begin
                    r_d.flag  = ~r_q.flag;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.op    = vpd_op_e'(r_q.op + 3'd1);
                    r_d.cs    = 1'b1;
                    r_d.tmr   = HALF_LD;
                    r_d.state = ST_CSUP;
                end
            end
            ST_STAT: begin
                if (r_q.tmr == '0) r_d.state = ST_POLL;
                else               r_d.tmr   = r_q.tmr - 1'b1;
            end
            ST_POLL: begin
                if (do_s) begin
                    r_d.cs    = 1'b0;
                    r_d.tmr   = HALF_LD;
                    r_d.state = ST_GAP;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign vpd_addr = r_q.addr;
    assign vpd_flag = r_q.flag;
    assign vpd_data = r_q.data;
    assign ee_cs    = r_q.cs;

    // R8: serial clock pulses only inside a chip-select window
    assert_sk_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ee_sk |-> ee_cs);

    // R7: address register frozen during a transfer
    assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> $stable(vpd_addr));

    // R7: store data frozen during a store
    assert_wdata_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE && r_q.flag) |=> $stable(vpd_data));

    // R3: flag moves only when the transfer ends
    assert_flag_flip_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> (vpd_flag == $past(vpd_flag)) || (r_q.state == ST_IDLE));

    // R9: ready polling happens with chip select up and the clock parked low
    assert_poll_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_POLL) |-> (ee_cs && !ee_sk));

endmodule

// File: tb/sim_vpd_eeprom_engine.sv
module sim_vpd_eeprom_engine;

    localparam int EE_ABITS = 8;
    localparam int SKH      = 4;
    localparam int TSV      = 6;
    localparam int AW       = EE_ABITS + 1;
    localparam int NWORDS   = 1 << EE_ABITS;
    localparam int HDR      = 3 + EE_ABITS;
    localparam int FULL     = HDR + 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_addr_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic          cfg_flag = 1'b0;
    logic          cfg_data_we = 1'b0;
    logic [31:0]   cfg_data = '0;
    logic [AW-1:0] vpd_addr;
    logic          vpd_flag;
    logic [31:0]   vpd_data;
    logic          ee_cs, ee_sk, ee_di, ee_do;

    always #5 clk = ~clk;

    vpd_eeprom_engine #(.EE_ABITS(EE_ABITS), .SK_HALF(SKH), .TSV_CYC(TSV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_we(cfg_addr_we), .cfg_addr(cfg_addr), .cfg_flag(cfg_flag),
        .cfg_data_we(cfg_data_we), .cfg_data(cfg_data),
        .vpd_addr(vpd_addr), .vpd_flag(vpd_flag), .vpd_data(vpd_data),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int checks = 0;
    int fails  = 0;

    function automatic logic [15:0] init_word(int i);
        return 16'(i * 273) ^ 16'hB00B;
    endfunction

    // ---------------- serial EEPROM model ----------------
    logic [15:0]     mem [0:NWORDS-1];
    logic [15:0]     shadow [0:NWORDS-1];
    int              busy_cycles = 40;
    bit              m_init;
    logic            m_cs_p, m_sk_p, m_ewen, m_wr_pend, m_rd, m_do;
    logic [FULL-1:0] m_sh;
    int              m_cnt, m_busy;
    logic [7:0]      m_wa;
    logic [15:0]     m_wd, m_rw;

    always @(negedge clk) begin
        if (!m_init) begin
            for (int i = 0; i < NWORDS; i++) mem[i] = init_word(i);
            m_cs_p = 0; m_sk_p = 0; m_ewen = 0; m_wr_pend = 0; m_rd = 0; m_do = 0;
            m_sh = '0; m_cnt = 0; m_busy = 0;
            m_init = 1'b1;
        end
        if (!ee_cs && m_cs_p) begin
            if (m_wr_pend && m_ewen) begin
                mem[m_wa] = m_wd;
                m_busy = busy_cycles;
            end
            m_wr_pend = 0; m_cnt = 0; m_rd = 0; m_sh = '0;
        end else if (m_busy > 0) begin
            m_busy = m_busy - 1;
        end
        if (ee_cs && ee_sk && !m_sk_p) begin
            m_sh  = {m_sh[FULL-2:0], ee_di};
            m_cnt = m_cnt + 1;
            if (m_rd) begin
                m_do = m_rw[15];
                m_rw = {m_rw[14:0], 1'b0};
            end else if (m_cnt == HDR) begin
                if (m_sh[HDR-1 -: 3] == 3'b110) begin
                    m_rd = 1; m_rw = mem[m_sh[7:0]]; m_do = 0;
                end else if (m_sh[HDR-1 -: 5] == 5'b10011) begin
                    m_ewen = 1;
                end
            end else if (m_cnt == FULL && m_sh[FULL-1 -: 3] == 3'b101) begin
                m_wr_pend = 1; m_wa = m_sh[23:16]; m_wd = m_sh[15:0];
            end
        end
        m_cs_p = ee_cs;
        m_sk_p = ee_sk;
    end

    assign ee_do = m_rd ? m_do : (m_busy > 0 ? 1'b0 : 1'b1);

    // ---------------- serial timing monitor (R8) ----------------
    int   hi_run, sk_pulses, tim_viol;
    logic mon_sk_p, mon_di_p;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ee_sk && !ee_cs) tim_viol++;
            if (ee_sk && mon_sk_p && ee_di != mon_di_p) tim_viol++;
            if (ee_sk) hi_run++;
            else begin
                if (mon_sk_p) begin
                    sk_pulses++;
                    if (hi_run != SKH) tim_viol++;
                end
                hi_run = 0;
            end
        end
        mon_sk_p = ee_sk;
        mon_di_p = ee_di;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                           output int taken);
        @(negedge clk);
        if (wr) begin
            cfg_data_we = 1'b1; cfg_data = d;
            @(negedge clk);
            cfg_data_we = 1'b0;
            chk("R2 staged data", vpd_data, d);
        end
        cfg_addr_we = 1'b1; cfg_addr = a; cfg_flag = wr;
        @(negedge clk);
        cfg_addr_we = 1'b0;
        chk("R3 flag after command", {31'd0, vpd_flag}, {31'd0, wr});
        taken = 0;
        while (vpd_flag == wr && taken < 30000) begin
            @(negedge clk);
            taken++;
        end
        chk("R3 flag inverted at end", {31'd0, vpd_flag}, {31'd0, ~wr});
        chk("R5 aligned address", {23'd0, vpd_addr}, {23'd0, a[AW-1:2], 2'b00});
    endtask

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [31:0]   data;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b1, 9'h000, 32'h11223344},
        '{1'b1, 9'h004, 32'hA5A55A5A},
        '{1'b1, 9'h1FC, 32'hDEADBEEF},
        '{1'b0, 9'h000, 32'h0},
        '{1'b0, 9'h004, 32'h0},
        '{1'b0, 9'h1FC, 32'h0},
        '{1'b0, 9'h040, 32'h0},
        '{1'b1, 9'h00B, 32'h0F0F00FF},
        '{1'b0, 9'h00A, 32'h0}
    };

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int taken;
        string tag;
        for (int i = 0; i < NWORDS; i++) shadow[i] = init_word(i);

        // R1: reset state, during and after reset
        repeat (4) @(negedge clk);
        chk("R1 flag", {31'd0, vpd_flag}, 32'd0);
        chk("R1 addr", {23'd0, vpd_addr}, 32'd0);
        chk("R1 data", vpd_data, 32'd0);
        chk("R1 bus", {29'd0, ee_cs, ee_sk, ee_di}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle after release", {28'd0, vpd_flag, ee_cs, ee_sk, ee_di}, 32'd0);

        // table walk: stores and fetches
        for (int v = 0; v < NV; v++) begin
            int w;
            logic [31:0] exp;
            w = int'({VECS[v].addr[AW-1:2], 1'b0});
            if (VECS[v].addr[1:0] != 2'b00)       tag = "R5";
            else if (VECS[v].addr == 9'h1FC)      tag = "R6";
            else if (VECS[v].wr)                  tag = "R2";
            else                                  tag = "R4";
            run_cmd(VECS[v].wr, VECS[v].addr, VECS[v].data, taken);
            if (VECS[v].wr) begin
                shadow[w]     = VECS[v].data[15:0];
                shadow[w + 1] = VECS[v].data[31:16];
                chk({tag, " low word stored"},  {16'd0, mem[w]},     {16'd0, shadow[w]});
                chk({tag, " high word stored"}, {16'd0, mem[w + 1]}, {16'd0, shadow[w + 1]});
            end else begin
                exp = {shadow[w + 1], shadow[w]};
                chk({tag, " fetched data"}, vpd_data, exp);
            end
        end
        chk("R2 byte order word0", {16'd0, mem[0]}, 32'h00003344);
        chk("R6 last word", {16'd0, mem[NWORDS - 1]}, 32'h0000DEAD);

        // R7: configuration writes during a fetch are dropped
        @(negedge clk);
        cfg_addr_we = 1'b1; cfg_addr = 9'h000; cfg_flag = 1'b0;
        @(negedge clk);
        cfg_addr_we = 1'b0;
        repeat (10) @(negedge clk);
        cfg_addr_we = 1'b1; cfg_addr = 9'h010; cfg_flag = 1'b1;
        cfg_data_we = 1'b1; cfg_data = 32'hCAFEF00D;
        @(negedge clk);
        cfg_addr_we = 1'b0; cfg_data_we = 1'b0;
        taken = 0;
        while (vpd_flag == 1'b0 && taken < 30000) begin
            @(negedge clk);
            taken++;
        end
        chk("R7 addr kept", {23'd0, vpd_addr}, 32'd0);
        chk("R7 data is fetch result", vpd_data, {shadow[1], shadow[0]});
        repeat (300) @(negedge clk);
        chk("R7 no store launched", {30'd0, vpd_flag, ee_cs}, 32'd2);
        chk("R7 eeprom word 8 intact", {16'd0, mem[8]}, {16'd0, shadow[8]});
        chk("R7 eeprom word 9 intact", {16'd0, mem[9]}, {16'd0, shadow[9]});

        // R9: slow EEPROM lengthens each word write by its busy time
        busy_cycles = 2000;
        run_cmd(1'b1, 9'h020, 32'h600DF00D, taken);
        checks++;
        if (taken < 4000) begin
            fails++;
            $display("FAIL R9 actual=%0d expected>=%0d", taken, 4000);
        end
        chk("R9 word stored", {mem[17], mem[16]}, 32'h600DF00D);
        busy_cycles = 40;

        // R8: serial clock shape
        chk("R8 clock pulses seen", {31'd0, sk_pulses > 100}, 32'd1);
        chk("R8 timing violations", tim_viol, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule